// File: doc/BRIEF.md
# Axis-Aligned Line Painter Stage

This stage sits in a raster pipeline and paints one single-pixel-wide line, either horizontal or vertical, into a stream of pixel chunks. Each chunk is eight pixels wide, one bit per pixel. It arrives tagged with its scan line and its chunk column on a 64x64 screen. Bit k of a chunk is the pixel at x = column*8 + k. A painted pixel is ORed onto the incoming bits. Chunks the line does not touch pass through unchanged. Every chunk leaves exactly one cycle after it enters, with its valid flag and tags carried alongside.

The line is given as a signed origin (x, y), a vertical flag and an unsigned pixel count. A vertical line covers rows y..y+len-1 at column x. A horizontal line covers columns x..x+len-1 on row y. A new description is held as pending and becomes live at the next vertical sync pulse, so a frame never shows half of one line and half of another. Coverage is worked out from absolute coordinates for every chunk. A line whose origin lies off screen, or whose far end runs past the edge, therefore paints only its visible pixels. Such a line is clipped from its interior without any stepping from the origin.

Top module: `line_stage`

## Requirements
- R1: After reset, valid_o is 0 and no line is live: until the first vsync_i pulse, every chunk passes through unchanged, even if a line was loaded.
- R2: A chunk presented with valid_i=1 appears one clock later with valid_o=1 and the same y and col tags; a cycle with valid_i=0 gives valid_o=0 one clock later.
- R3: The stage only sets bits: every bit that is 1 at pix_i is 1 at pix_o, and a chunk not touched by the line leaves unchanged.
- R4: For a live vertical line (vert=1), a chunk on a row from y to y+len-1 has exactly bit (x mod 8) set if its column equals x div 8, and nothing is set in any other chunk.
- R5: For a live horizontal line (vert=0) on row y, a chunk whose eight pixels all lie within x..x+len-1 is output as all ones.
- R6: For a horizontal line, a chunk holding the left end sets bits from (x mod 8) upward. A chunk holding the right end sets bits up to ((x+len-1) mod 8). A chunk holding both ends sets only the bits between them, inclusive.
- R7: load_i stores a new line as pending without changing the live line; the pending line becomes live on a vsync_i pulse, and a load in the same cycle as vsync_i becomes live at once.
- R8: Origins may be negative or far out (signed, 8 bits) and a line may extend past the screen edge; exactly the on-screen pixels of the line are painted, and a line wholly off screen paints nothing.
- R9: A line with len=0 paints nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Store org_x_i, org_y_i, vert_i, len_i as the pending line |
| org_x_i | input | 8 | Origin x, signed two's complement |
| org_y_i | input | 8 | Origin y, signed two's complement |
| vert_i | input | 1 | 1 = vertical line, 0 = horizontal |
| len_i | input | 8 | Line length in pixels, unsigned |
| vsync_i | input | 1 | Frame start; makes the pending line live |
| valid_i | input | 1 | Input chunk valid |
| y_i | input | 6 | Scan line of the input chunk |
| col_i | input | 3 | Chunk column of the input chunk |
| pix_i | input | 8 | Input chunk pixels, bit k = pixel col*8+k |
| valid_o | output | 1 | Output chunk valid |
| y_o | output | 6 | Scan line of the output chunk |
| col_o | output | 3 | Chunk column of the output chunk |
| pix_o | output | 8 | Output chunk pixels with the line painted in |

## Verification
On every cycle, the assertions check the one-cycle valid and tag transport and that no incoming bit is ever cleared. They also check that a vertical line contributes at most one bit per chunk, that nothing is painted before the first vsync, and that the live line holds between sync pulses. Whether the right bits are set only shows in the bench's full-frame sweeps. These sweeps cover full, partial and single-chunk spans, clipping at each of the four edges, wholly off-screen and zero-length lines, and the pending/live hand-over. Every pixel of every frame is compared with a per-pixel coordinate model.

// File: rtl/line_stage_pkg.sv
package line_stage_pkg;
  localparam int SCR_W   = 64;
  localparam int SCR_H   = 64;
  localparam int CHUNK_W = 8;   // power of two
  localparam int COORD_W = 8;
  localparam int LEN_W   = 8;
  localparam int Y_W     = $clog2(SCR_H);
  localparam int COL_W   = $clog2(SCR_W / CHUNK_W);
  localparam int OFS_W   = $clog2(CHUNK_W);
  localparam int EXT_W   = ((COORD_W > LEN_W) ? COORD_W : LEN_W) + 2;

  typedef struct packed {
    logic signed [COORD_W-1:0] x;
    logic signed [COORD_W-1:0] y;
    logic                      vert;
    logic [LEN_W-1:0]          len;
  } line_t;
endpackage

// File: rtl/line_regs.sv
module line_regs
  import line_stage_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  line_t line_i,
  input  logic  vsync_i,
  output line_t act_o,
  output logic  armed_o
);
  line_t pend_q;
  logic  pend_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= '0;
      pend_ok_q <= 1'b0;
      act_o     <= '0;
      armed_o   <= 1'b0;
    end else begin
      if (load_i) begin
        pend_q    <= line_i;
        pend_ok_q <= 1'b1;
      end
      if (vsync_i) begin
        act_o   <= load_i ? line_i : pend_q;
        armed_o <= load_i | pend_ok_q;
      end
    end
  end

  AST_LIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_i |=> ($stable(act_o) && $stable(armed_o))); // R7
endmodule

// File: rtl/line_cover.sv
module line_cover
  import line_stage_pkg::*;
(
  input  line_t              ln_i,
  input  logic               armed_i,
  input  logic [Y_W-1:0]     y_i,
  input  logic [COL_W-1:0]   col_i,
  output logic [CHUNK_W-1:0] mask_o
);
  logic signed [EXT_W-1:0] ox, oy, len_s, end_c, yv, cl, ch;
  logic [CHUNK_W-1:0] lo_m, hi_m;
  logic [OFS_W-1:0]   rsh;
  logic               live, hit_h, hit_v;

  always_comb begin
    ox    = EXT_W'(ln_i.x);
    oy    = EXT_W'(ln_i.y);
    len_s = signed'(EXT_W'(ln_i.len));
    end_c = (ln_i.vert ? oy : ox) + len_s - EXT_W'(1);
    yv    = signed'(EXT_W'(y_i));
    cl    = signed'(EXT_W'({col_i, {OFS_W{1'b0}}}));
    ch    = cl + EXT_W'(CHUNK_W - 1);
    live  = armed_i && (ln_i.len != '0);

    hit_h = live && !ln_i.vert && (yv == oy) && (ox <= ch) && (end_c >= cl);
    hit_v = live &&  ln_i.vert && (yv >= oy) && (yv <= end_c) &&
            (ox >= cl) && (ox <= ch);

    // left border from start offset, right border from end offset
    rsh  = ~end_c[OFS_W-1:0];
    lo_m = (ox <= cl)    ? '1 : ({CHUNK_W{1'b1}} << ox[OFS_W-1:0]);
    hi_m = (end_c >= ch) ? '1 : ({CHUNK_W{1'b1}} >> rsh);

    mask_o = '0;
    if (hit_h)      mask_o = lo_m & hi_m;
    else if (hit_v) mask_o = CHUNK_W'(1) << ox[OFS_W-1:0];
  end
endmodule

// File: rtl/line_stage.sv
module line_stage
  import line_stage_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [COORD_W-1:0]  org_x_i,
  input  logic [COORD_W-1:0]  org_y_i,
  input  logic                vert_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                vsync_i,
  input  logic                valid_i,
  input  logic [Y_W-1:0]      y_i,
  input  logic [COL_W-1:0]    col_i,
  input  logic [CHUNK_W-1:0]  pix_i,
  output logic                valid_o,
  output logic [Y_W-1:0]      y_o,
  output logic [COL_W-1:0]    col_o,
  output logic [CHUNK_W-1:0]  pix_o
);
  line_t              new_line, act;
  logic               armed;
  logic [CHUNK_W-1:0] mask;

  assign new_line = '{x: signed'(org_x_i), y: signed'(org_y_i),
                      vert: vert_i, len: len_i};

  line_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .line_i  (new_line),
    .vsync_i (vsync_i),
    .act_o   (act),
    .armed_o (armed)
  );

  line_cover u_cover (
    .ln_i    (act),
    .armed_i (armed),
    .y_i     (y_i),
    .col_i   (col_i),
    .mask_o  (mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y_o     <= '0;
      col_o   <= '0;
      pix_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        y_o   <= y_i;
        col_o <= col_i;
        pix_o <= pix_i | mask;
      end
    end
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (valid_o && y_o == $past(y_i) && col_o == $past(col_i))); // R2
  AST_IDLE_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R2
  AST_KEEP_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((pix_o & $past(pix_i)) == $past(pix_i))); // R3
  AST_VERT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && act.vert) |-> $onehot0(mask)); // R4
  AST_NONE_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> (mask == '0)); // R1
endmodule

// File: tb/line_stage_tb.sv
`timescale 1ns/1ps
module line_stage_tb;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       load_i = 0, vert_i = 0, vsync_i = 0, valid_i = 0;
  logic [7:0] org_x_i = 0, org_y_i = 0, len_i = 0, pix_i = 0;
  logic [5:0] y_i = 0;
  logic [2:0] col_i = 0;
  logic       valid_o;
  logic [5:0] y_o;
  logic [2:0] col_o;
  logic [7:0] pix_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  // bench model of the live line
  int  m_x, m_y, m_len;
  bit  m_vert, m_arm = 0;
  int  p_x, p_y, p_len;
  bit  p_vert, p_ok = 0;

  always #2.5 clk_i = ~clk_i;

  line_stage u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mask(input int y, input int c);
    logic [7:0] m = '0;
    if (!m_arm || m_len == 0) return m;
    for (int k = 0; k < 8; k++) begin
      int x = c * 8 + k;
      if (m_vert) begin
        if (x == m_x && y >= m_y && y <= m_y + m_len - 1) m[k] = 1'b1;
      end else begin
        if (y == m_y && x >= m_x && x <= m_x + m_len - 1) m[k] = 1'b1;
      end
    end
    return m;
  endfunction

  task automatic load(input int x, input int y, input bit v, input int len, input bit sync);
    @(negedge clk_i);
    load_i = 1; org_x_i = 8'(x); org_y_i = 8'(y); vert_i = v; len_i = 8'(len);
    vsync_i = sync;
    p_x = x; p_y = y; p_vert = v; p_len = len; p_ok = 1;
    @(negedge clk_i);
    load_i = 0; vsync_i = 0;
    if (sync) begin m_x = p_x; m_y = p_y; m_vert = p_vert; m_len = p_len; m_arm = 1; end
  endtask

  task automatic vsync();
    @(negedge clk_i);
    vsync_i = 1;
    @(negedge clk_i);
    vsync_i = 0;
    if (p_ok) begin m_x = p_x; m_y = p_y; m_vert = p_vert; m_len = p_len; m_arm = 1; end
  endtask

  task automatic frame(input string tag, input int seed);
    for (int y = 0; y < 64; y++) begin
      for (int c = 0; c < 8; c++) begin
        logic [7:0] pin, expv;
        pin = 8'((y * 37 + c * 11 + seed * 13) & 8'h93);
        @(negedge clk_i);
        valid_i = 1; y_i = 6'(y); col_i = 3'(c); pix_i = pin;
        @(negedge clk_i);
        valid_i = 0;
        expv = pin | exp_mask(y, c);
        chk(valid_o && y_o == 6'(y) && col_o == 3'(c), "R2 tags",
            {valid_o, y_o, col_o}, {1'b1, 6'(y), 3'(c)});
        chk(pix_o == expv, tag, pix_o, expv);
      end
    end
    @(negedge clk_i);
    chk(!valid_o, "R2 idle", valid_o, 0);
  endtask

  initial begin
    #1;
    chk(valid_o == 1'b0, "R1 reset valid", valid_o, 0);
    #10 rst_ni = 1'b1;
    // R1: loaded but no vsync yet -> untouched
    load(0, 5, 0, 64, 0);
    frame("R1 no vsync", 1);
    vsync();
    frame("R5 full row", 2);
    load(3, 10, 0, 2, 1);
    frame("R6 single chunk", 3);
    load(5, 12, 0, 20, 1);
    frame("R6 R5 span", 4);
    load(17, 3, 1, 9, 1);
    frame("R4 vertical", 5);
    load(63, 60, 1, 10, 1);
    frame("R8 clip bottom", 6);
    load(-10, 20, 0, 15, 1);
    frame("R8 clip left", 7);
    load(30, -5, 1, 8, 1);
    frame("R8 clip top", 8);
    load(60, 40, 0, 100, 1);
    frame("R8 clip right", 9);
    load(-50, 70, 0, 5, 1);
    frame("R8 off screen", 10);
    load(4, 4, 0, 0, 1);
    frame("R9 zero length", 11);
    // R7: pending only until vsync
    load(8, 33, 0, 16, 1);
    load(40, 0, 1, 64, 0);
    frame("R7 pending held", 12);
    vsync();
    frame("R7 after vsync", 13);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule